// File: doc/BRIEF.md
# USB Host Command, Status and Interrupt Control

This block is the control core of a USB 2.0 host controller. Software reaches it through a small register port: a command word (run/stop, host reset, schedule enables, a doorbell that asks to be told when the asynchronous schedule has advanced, and an interrupt pacing threshold), a status word and an interrupt enable word. The schedule engine reports to it through single-cycle event pulses: transaction complete, error, port change, frame-list rollover, system error and cache-evicted acknowledge. It also supplies a level that says its transaction pipeline is idle, plus a tick at every micro-frame.

Stopping is not immediate. Once run is cleared, the block waits for the pipeline to drain and then reports halted. A drain timer forces the halted state after a fixed number of micro-frames. Interrupt status bits are set by hardware and cleared by writing one. The interrupt line is released only on a threshold boundary counted in micro-frame ticks. A host reset returns every register to its initial value for a fixed number of cycles and then clears itself.

Register port addresses: 0 = command, 1 = status, 2 = interrupt enable, 3 reads zero. Reads are combinational. A write takes effect at the clock edge on which `reg_wr` is high. The port has no back-pressure: every write is accepted in its cycle, except during a host reset, when writes are dropped.

Top module: `uhc_cmd_stat`

## Requirements
- R1: After reset the command word reads 0x00080000 (threshold 8 in bits 23:16, all else 0), status reads 0x00001000 (bit 12 halted), the enable word reads 0, and `irq` is 0 and `halted` is 1.
- R2: Writing command bit 0 = 1 while halted clears `halted` and status bit 12 at that edge; status bit 12 never reads 1 while command bit 0 reads 1.
- R3: Writing command bit 0 = 0 while running enters a drain phase. `halted` becomes 1 one cycle after `pipe_idle` is seen high in that phase. If `pipe_idle` stays low, `halted` becomes 1 on the 16th `mf_tick` (DRAIN_TICKS) counted from the stop write.
- R4: Writing command bit 1 = 1 starts a host reset. For RST_CYCLES (4) cycles command bit 1 reads 1, all registers hold their R1 values and register writes are dropped, including a write of 0 to bit 1. After that, bit 1 reads 0.
- R5: Writing command bit 6 = 1 rings the doorbell. An `evict_ack` while it reads 1 sets status bit 5 on that edge, and bit 6 reads 0 one cycle later. An `evict_ack` while bit 6 reads 0 sets nothing.
- R6: Status bits 0..5 (complete, error, port change, rollover, system error, async advance) are set by their events. Writing 1 to a bit position of the status word clears that bit; writing 0 leaves it unchanged.
- R7: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R8: An `ev_err_ioc` pulse sets both status bit 0 and status bit 1.
- R9: `irq` rises only after the `mf_tick` that completes a threshold period, and only if some status bit 0..5 is set with the matching enable bit (same position, enable word). It falls one cycle after no enabled bit is pending.
- R10: A command write whose bits 23:16 differ from the current threshold restarts the tick count of the period.
- R11: Status bits 14 and 15 and the outputs `sched_per_en` and `sched_async_en` copy command bits 4 and 5 only on an `mf_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 command, 1 status, 2 enable) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mf_tick | input | 1 | One-cycle pulse per micro-frame |
| pipe_idle | input | 1 | Schedule engine has no transaction in flight |
| ev_cmpl | input | 1 | Transaction completed with interrupt request |
| ev_err | input | 1 | Transaction ended in error |
| ev_err_ioc | input | 1 | Error on a transaction that also requested an interrupt |
| ev_port | input | 1 | Port change |
| ev_roll | input | 1 | Frame list rollover |
| ev_syserr | input | 1 | Host system error |
| evict_ack | input | 1 | Cached asynchronous state has been evicted |
| irq | output | 1 | Paced interrupt request |
| halted | output | 1 | Controller is halted |
| sched_per_en | output | 1 | Periodic schedule active |
| sched_async_en | output | 1 | Asynchronous schedule active |

## Verification
The bench builds the block with its defaults: a 16-tick drain bound, a 4-cycle host reset and a reset threshold of 8. It then writes thresholds of 2 and 4, so that complete pacing periods fit in a few ticks. The short threshold makes it cheap to tell a restarted count from a running one, because a count that was not restarted fires one tick early. The default drain bound keeps the timeout path within reach: the bench can show that the 15th tick leaves the block running and the 16th halts it.

// File: rtl/uhc_pkg.sv
package uhc_pkg;
  localparam logic [1:0] A_CMD = 2'd0;
  localparam logic [1:0] A_STS = 2'd1;
  localparam logic [1:0] A_IEN = 2'd2;

  localparam int unsigned NSRC   = 6;
  localparam int unsigned THR_W  = 8;

  localparam int unsigned CB_RUN    = 0;
  localparam int unsigned CB_HRST   = 1;
  localparam int unsigned CB_PSEN   = 4;
  localparam int unsigned CB_ASEN   = 5;
  localparam int unsigned CB_BELL   = 6;
  localparam int unsigned CB_THR_LO = 16;

  localparam int unsigned SB_HALT = 12;
  localparam int unsigned SB_PSS  = 14;
  localparam int unsigned SB_ASS  = 15;

  localparam int unsigned EV_CMPL = 0;
  localparam int unsigned EV_ERR  = 1;
  localparam int unsigned EV_PORT = 2;
  localparam int unsigned EV_ROLL = 3;
  localparam int unsigned EV_SYSE = 4;
  localparam int unsigned EV_IAA  = 5;

  typedef enum logic [1:0] {
    RS_HALTED   = 2'd0,
    RS_RUNNING  = 2'd1,
    RS_DRAINING = 2'd2
  } run_state_e;
endpackage

// File: rtl/uhc_run_ctl.sv
module uhc_run_ctl
  import uhc_pkg::*;
#(
  parameter int unsigned DRAIN_TICKS = 16,
  parameter int unsigned RST_CYCLES  = 4,
  parameter int unsigned THR_INIT    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic             wr_run,
  input  logic             wr_hrst,
  input  logic             wr_psen,
  input  logic             wr_asen,
  input  logic             wr_bell,
  input  logic [THR_W-1:0] wr_thr,
  input  logic             mf_tick,
  input  logic             pipe_idle,
  input  logic             evict_ack,
  output logic             run_q,
  output logic             hrst_busy,
  output logic             init_o,
  output logic             halted,
  output logic             psen_q,
  output logic             asen_q,
  output logic             pss_q,
  output logic             ass_q,
  output logic             bell_q,
  output logic             iaa_set,
  output logic [THR_W-1:0] thr_q,
  output logic             thr_restart
);
  localparam int unsigned DW = $clog2(DRAIN_TICKS + 1);
  localparam int unsigned RW = $clog2(RST_CYCLES + 1);
  localparam logic [DW-1:0] DRAIN_LAST = DW'(DRAIN_TICKS - 1);
  localparam logic [RW-1:0] RST_LOAD   = RW'(RST_CYCLES);
  localparam logic [THR_W-1:0] THR_DEF = THR_W'(THR_INIT);

  run_state_e    state;
  logic [DW-1:0] drain_cnt;
  logic [RW-1:0] rst_cnt;
  logic          bell_pend;
  logic          hrst_start;
  logic          sw_we;

  assign hrst_busy   = (rst_cnt != '0);
  assign hrst_start  = cmd_we && wr_hrst && !hrst_busy;
  assign init_o      = hrst_start || hrst_busy;
  assign sw_we       = cmd_we && !init_o;
  assign halted      = (state == RS_HALTED);
  assign iaa_set     = evict_ack && bell_q && !init_o;
  assign thr_restart = sw_we && (wr_thr != thr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RS_HALTED;
      run_q     <= 1'b0;
      drain_cnt <= '0;
      rst_cnt   <= '0;
      psen_q    <= 1'b0;
      asen_q    <= 1'b0;
      pss_q     <= 1'b0;
      ass_q     <= 1'b0;
      bell_q    <= 1'b0;
      bell_pend <= 1'b0;
      thr_q     <= THR_DEF;
    end else if (init_o) begin
      state     <= RS_HALTED;
      run_q     <= 1'b0;
      drain_cnt <= '0;
      rst_cnt   <= hrst_start ? RST_LOAD : rst_cnt - 1'b1;
      psen_q    <= 1'b0;
      asen_q    <= 1'b0;
      pss_q     <= 1'b0;
      ass_q     <= 1'b0;
      bell_q    <= 1'b0;
      bell_pend <= 1'b0;
      thr_q     <= THR_DEF;
    end else begin
      if (sw_we) begin
        psen_q <= wr_psen;
        asen_q <= wr_asen;
        thr_q  <= wr_thr;
      end
      if (mf_tick) begin
        pss_q <= psen_q;
        ass_q <= asen_q;
      end
      bell_pend <= iaa_set;
      if (bell_pend)              bell_q <= 1'b0;
      else if (sw_we && wr_bell)  bell_q <= 1'b1;
      case (state)
        RS_HALTED: begin
          if (sw_we && wr_run) begin
            run_q <= 1'b1;
            state <= RS_RUNNING;
          end
        end
        RS_RUNNING: begin
          if (sw_we && !wr_run) begin
            run_q     <= 1'b0;
            drain_cnt <= '0;
            state     <= RS_DRAINING;
          end
        end
        RS_DRAINING: begin
          if (pipe_idle) begin
            state <= RS_HALTED;
          end else if (mf_tick) begin
            if (drain_cnt == DRAIN_LAST) state <= RS_HALTED;
            else                         drain_cnt <= drain_cnt + 1'b1;
          end
        end
        default: state <= RS_HALTED;
      endcase
    end
  end

  a_r2_halt_excl_run: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !run_q);

  a_r3_timeout_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RS_DRAINING && !pipe_idle && mf_tick && !init_o && drain_cnt == DRAIN_LAST) |=> halted);

  a_r3_idle_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RS_DRAINING && pipe_idle) |=> halted);

  a_r4_busy_halted: assert property (@(posedge clk) disable iff (!rst_n)
    hrst_busy |-> (halted && !bell_q && thr_q == THR_DEF));

  a_r11_sched_lag: assert property (@(posedge clk) disable iff (!rst_n)
    (!mf_tick && !init_o) |=> ($stable(pss_q) && $stable(ass_q)));
endmodule

// File: rtl/uhc_int_status.sv
module uhc_int_status
  import uhc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init,
  input  logic            sts_we,
  input  logic            ien_we,
  input  logic [NSRC-1:0] wdata,
  input  logic [NSRC-1:0] set_vec,
  output logic [NSRC-1:0] sts_q,
  output logic [NSRC-1:0] ien_q,
  output logic            pend_any
);
  assign pend_any = |(sts_q & ien_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ien_q <= '0;
    else if (init)              ien_q <= '0;
    else if (ien_we)            ien_q <= wdata;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sts_q[i] <= 1'b0;
      else if (init)  sts_q[i] <= 1'b0;
      else            sts_q[i] <= set_vec[i] | (sts_q[i] & ~(sts_we & wdata[i]));
    end

    a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n || init)
      set_vec[i] |=> sts_q[i]);

    a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_we && wdata[i] && !set_vec[i]) |=> !sts_q[i]);
  end
endmodule

// File: rtl/uhc_int_pacer.sv
module uhc_int_pacer
  import uhc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             restart,
  input  logic             tick,
  input  logic [THR_W-1:0] thr,
  input  logic             pend_any,
  output logic             irq
);
  logic [THR_W-1:0] cnt;
  logic [THR_W:0]   nxt;
  logic             bound;

  assign nxt   = {1'b0, cnt} + 1'b1;
  assign bound = tick && !restart && (nxt >= {1'b0, thr});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      irq <= 1'b0;
    end else if (init) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      if (restart || bound) cnt <= '0;
      else if (tick)        cnt <= nxt[THR_W-1:0];
      irq <= bound ? pend_any : (irq && pend_any);
    end
  end

  a_r9_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick));

  a_r9_drop_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !pend_any) |=> !irq);
endmodule

// File: rtl/uhc_cmd_stat.sv
module uhc_cmd_stat
  import uhc_pkg::*;
#(
  parameter int unsigned DRAIN_TICKS = 16,
  parameter int unsigned RST_CYCLES  = 4,
  parameter int unsigned THR_INIT    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        mf_tick,
  input  logic        pipe_idle,
  input  logic        ev_cmpl,
  input  logic        ev_err,
  input  logic        ev_err_ioc,
  input  logic        ev_port,
  input  logic        ev_roll,
  input  logic        ev_syserr,
  input  logic        evict_ack,
  output logic        irq,
  output logic        halted,
  output logic        sched_per_en,
  output logic        sched_async_en
);
  logic             run_q, hrst_busy, init, psen_q, asen_q, pss_q, ass_q;
  logic             bell_q, iaa_set, thr_restart, pend_any;
  logic [THR_W-1:0] thr_q;
  logic [NSRC-1:0]  sts_q, ien_q, set_vec;
  logic             cmd_we, sts_we, ien_we;
  logic             unused_wdata;

  assign cmd_we = reg_wr && (reg_addr == A_CMD);
  assign sts_we = reg_wr && (reg_addr == A_STS) && !init;
  assign ien_we = reg_wr && (reg_addr == A_IEN) && !init;
  assign unused_wdata = ^{reg_wdata[31:24], reg_wdata[15:7], reg_wdata[3:2]};

  always_comb begin
    set_vec          = '0;
    set_vec[EV_CMPL] = ev_cmpl | ev_err_ioc;
    set_vec[EV_ERR]  = ev_err | ev_err_ioc;
    set_vec[EV_PORT] = ev_port;
    set_vec[EV_ROLL] = ev_roll;
    set_vec[EV_SYSE] = ev_syserr;
    set_vec[EV_IAA]  = iaa_set;
  end

  uhc_run_ctl #(
    .DRAIN_TICKS(DRAIN_TICKS),
    .RST_CYCLES (RST_CYCLES),
    .THR_INIT   (THR_INIT)
  ) u_run (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_we     (cmd_we),
    .wr_run     (reg_wdata[CB_RUN]),
    .wr_hrst    (reg_wdata[CB_HRST]),
    .wr_psen    (reg_wdata[CB_PSEN]),
    .wr_asen    (reg_wdata[CB_ASEN]),
    .wr_bell    (reg_wdata[CB_BELL]),
    .wr_thr     (reg_wdata[CB_THR_LO +: THR_W]),
    .mf_tick    (mf_tick),
    .pipe_idle  (pipe_idle),
    .evict_ack  (evict_ack),
    .run_q      (run_q),
    .hrst_busy  (hrst_busy),
    .init_o     (init),
    .halted     (halted),
    .psen_q     (psen_q),
    .asen_q     (asen_q),
    .pss_q      (pss_q),
    .ass_q      (ass_q),
    .bell_q     (bell_q),
    .iaa_set    (iaa_set),
    .thr_q      (thr_q),
    .thr_restart(thr_restart)
  );

  uhc_int_status u_sts (
    .clk     (clk),
    .rst_n   (rst_n),
    .init    (init),
    .sts_we  (sts_we),
    .ien_we  (ien_we),
    .wdata   (reg_wdata[NSRC-1:0]),
    .set_vec (set_vec),
    .sts_q   (sts_q),
    .ien_q   (ien_q),
    .pend_any(pend_any)
  );

  uhc_int_pacer u_pace (
    .clk     (clk),
    .rst_n   (rst_n),
    .init    (init),
    .restart (thr_restart),
    .tick    (mf_tick),
    .thr     (thr_q),
    .pend_any(pend_any),
    .irq     (irq)
  );

  assign sched_per_en   = pss_q;
  assign sched_async_en = ass_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CMD: begin
        reg_rdata[CB_RUN]              = run_q;
        reg_rdata[CB_HRST]             = hrst_busy;
        reg_rdata[CB_PSEN]             = psen_q;
        reg_rdata[CB_ASEN]             = asen_q;
        reg_rdata[CB_BELL]             = bell_q;
        reg_rdata[CB_THR_LO +: THR_W]  = thr_q;
      end
      A_STS: begin
        reg_rdata[NSRC-1:0] = sts_q;
        reg_rdata[SB_HALT]  = halted;
        reg_rdata[SB_PSS]   = pss_q;
        reg_rdata[SB_ASS]   = ass_q;
      end
      A_IEN:   reg_rdata[NSRC-1:0] = ien_q;
      default: reg_rdata = '0;
    endcase
  end

  a_r5_bell_after_iaa: assert property (@(posedge clk) disable iff (!rst_n || init)
    $fell(bell_q) |-> $past(sts_q[EV_IAA]));

  a_r8_ioc_err_both: assert property (@(posedge clk) disable iff (!rst_n || init)
    ev_err_ioc |=> (sts_q[EV_CMPL] && sts_q[EV_ERR]));
endmodule

// File: tb/uhc_cmd_stat_bench.sv
`timescale 1ns/10ps
module uhc_cmd_stat_bench;
  import uhc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mf_tick = 1'b0, pipe_idle = 1'b0;
  logic        ev_cmpl = 1'b0, ev_err = 1'b0, ev_err_ioc = 1'b0, ev_port = 1'b0;
  logic        ev_roll = 1'b0, ev_syserr = 1'b0, evict_ack = 1'b0;
  logic        irq, halted, sched_per_en, sched_async_en;

  always #2.5 clk = ~clk;

  uhc_cmd_stat u_uhc_cmd_stat (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mf_tick(mf_tick),
    .pipe_idle(pipe_idle), .ev_cmpl(ev_cmpl), .ev_err(ev_err),
    .ev_err_ioc(ev_err_ioc), .ev_port(ev_port), .ev_roll(ev_roll),
    .ev_syserr(ev_syserr), .evict_ack(evict_ack), .irq(irq), .halted(halted),
    .sched_per_en(sched_per_en), .sched_async_en(sched_async_en)
  );

  typedef struct {
    int          sel;
    logic [31:0] mask;
    logic [31:0] exp;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  event mon_ev;
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  localparam int S_IRQ = 3, S_HALT = 4, S_SCHED = 5;

  function automatic logic [31:0] observe(input int sel);
    case (sel)
      S_IRQ:   return {31'b0, irq};
      S_HALT:  return {31'b0, halted};
      S_SCHED: return {30'b0, sched_async_en, sched_per_en};
      default: return reg_rdata;
    endcase
  endfunction

  // monitor: pops expected items and compares with what the design shows
  initial begin
    forever begin
      @(mon_ev);
      while (sb_q.size() > 0) begin
        exp_t e;
        logic [31:0] got;
        e = sb_q.pop_front();
        got = observe(e.sel) & e.mask;
        checks++;
        if (got !== (e.exp & e.mask)) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", e.tag, got, e.exp & e.mask);
        end
      end
    end
  end

  // driver side: queue one expectation and hand it to the monitor
  task automatic chk(input int sel, input logic [31:0] mask, input logic [31:0] exp, input string tag);
    exp_t e;
    if (sel < 3) reg_addr = sel[1:0];
    e.sel = sel; e.mask = mask; e.exp = exp; e.tag = tag;
    sb_q.push_back(e);
    #0.1;
    -> mon_ev;
    #0.1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      mf_tick = 1'b1;
      @(negedge clk);
      mf_tick = 1'b0;
    end
  endtask

  // order: evict, syserr, roll, port, err_ioc, err, cmpl
  task automatic pulse(input logic [6:0] v);
    {evict_ack, ev_syserr, ev_roll, ev_port, ev_err_ioc, ev_err, ev_cmpl} = v;
    @(negedge clk);
    {evict_ack, ev_syserr, ev_roll, ev_port, ev_err_ioc, ev_err, ev_cmpl} = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    // R1 reset values
    chk(0, 32'hFFFF_FFFF, 32'h0008_0000, "R1 cmd reset");
    chk(1, 32'hFFFF_FFFF, 32'h0000_1000, "R1 status reset");
    chk(2, 32'hFFFF_FFFF, 32'h0, "R1 enable reset");
    chk(S_IRQ, 32'h1, 32'h0, "R1 irq reset");
    chk(S_HALT, 32'h1, 32'h1, "R1 halted reset");

    // R2 run
    wr(A_CMD, 32'h0008_0001);
    chk(S_HALT, 32'h1, 32'h0, "R2 halted cleared by run");
    chk(1, 32'hFFFF_FFFF, 32'h0, "R2 status bit12 low while running");

    // R11 schedule status lags to the tick
    wr(A_CMD, 32'h0008_0031);
    chk(S_SCHED, 32'h3, 32'h0, "R11 no change before tick");
    chk(1, 32'h0000_C000, 32'h0, "R11 status bits before tick");
    ticks(1);
    chk(S_SCHED, 32'h3, 32'h3, "R11 outputs after tick");
    chk(1, 32'h0000_C000, 32'h0000_C000, "R11 status bits after tick");

    // R6 / R8 status set and write-one-to-clear
    pulse(7'b0000001);
    chk(1, 32'h3F, 32'h01, "R6 completion sets bit0");
    pulse(7'b0000100);
    chk(1, 32'h3F, 32'h03, "R8 error with ioc sets bits 0 and 1");
    wr(A_STS, 32'h01);
    chk(1, 32'h3F, 32'h02, "R6 w1c clears bit0");
    wr(A_STS, 32'h00);
    chk(1, 32'h3F, 32'h02, "R6 write zero no effect");
    pulse(7'b0111000);
    chk(1, 32'h3F, 32'h1E, "R6 port roll syserr set");
    wr(A_STS, 32'h1E);
    chk(1, 32'h3F, 32'h00, "R6 w1c clears several");

    // R7 event wins over a same-cycle clear
    reg_wr = 1'b1; reg_addr = A_STS; reg_wdata = 32'h08; ev_roll = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; ev_roll = 1'b0;
    chk(1, 32'h3F, 32'h08, "R7 event beats clear");

    // R9 pacing with threshold 2
    wr(A_IEN, 32'h3F);
    wr(A_CMD, 32'h0002_0031);
    chk(S_IRQ, 32'h1, 32'h0, "R9 no irq before boundary");
    ticks(1);
    chk(S_IRQ, 32'h1, 32'h0, "R9 no irq mid period");
    ticks(1);
    chk(S_IRQ, 32'h1, 32'h1, "R9 irq at boundary");
    wr(A_STS, 32'h08);
    chk(S_IRQ, 32'h1, 32'h1, "R9 irq held one cycle after clear");
    step(1);
    chk(S_IRQ, 32'h1, 32'h0, "R9 irq falls");

    // R10 restart on threshold change
    pulse(7'b0000001);
    ticks(1);
    wr(A_CMD, 32'h0004_0031);
    ticks(3);
    chk(S_IRQ, 32'h1, 32'h0, "R10 count restarted");
    ticks(1);
    chk(S_IRQ, 32'h1, 32'h1, "R10 irq after full new period");
    wr(A_STS, 32'h01);
    step(1);

    // R9 disabled source does not interrupt
    wr(A_IEN, 32'h00);
    pulse(7'b0001000);
    ticks(4);
    chk(S_IRQ, 32'h1, 32'h0, "R9 masked source no irq");
    wr(A_STS, 32'h04);
    wr(A_IEN, 32'h3F);

    // R5 doorbell
    pulse(7'b1000000);
    chk(1, 32'h20, 32'h0, "R5 evict without doorbell ignored");
    wr(A_CMD, 32'h0004_0071);
    chk(0, 32'h40, 32'h40, "R5 doorbell reads set");
    pulse(7'b1000000);
    chk(1, 32'h20, 32'h20, "R5 async advance status set");
    chk(0, 32'h40, 32'h40, "R5 doorbell still set with status");
    step(1);
    chk(0, 32'h40, 32'h0, "R5 doorbell cleared after status");
    wr(A_STS, 32'h20);

    // R3 stop with idle pipeline
    pipe_idle = 1'b1;
    wr(A_CMD, 32'h0004_0030);
    chk(S_HALT, 32'h1, 32'h0, "R3 draining not halted yet");
    step(1);
    chk(S_HALT, 32'h1, 32'h1, "R3 halted after idle");
    chk(1, 32'h1000, 32'h1000, "R3 status bit12 set");

    // R3 drain timeout
    pipe_idle = 1'b0;
    wr(A_CMD, 32'h0004_0031);
    chk(S_HALT, 32'h1, 32'h0, "R3 running again");
    wr(A_CMD, 32'h0004_0030);
    ticks(15);
    chk(S_HALT, 32'h1, 32'h0, "R3 not halted after 15 ticks");
    ticks(1);
    chk(S_HALT, 32'h1, 32'h1, "R3 halted on 16th tick");

    // R4 host reset
    wr(A_CMD, 32'h0000_0002);
    chk(0, 32'hFFFF_FFFF, 32'h0008_0002, "R4 reset in progress");
    wr(A_IEN, 32'h3F);
    wr(A_CMD, 32'h0000_0000);
    chk(0, 32'h2, 32'h2, "R4 zero write cannot end reset");
    step(2);
    chk(0, 32'hFFFF_FFFF, 32'h0008_0000, "R4 cmd back to default");
    chk(2, 32'hFFFF_FFFF, 32'h0, "R4 enable write dropped");
    chk(1, 32'hFFFF_FFFF, 32'h0000_1000, "R4 status default");
    chk(S_SCHED, 32'h3, 32'h0, "R4 schedules off");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule